// File: doc/BRIEF.md
# Serial Huffman Code-Tree Walker

This block turns a serial stream of Huffman-coded bits into decoded symbols. The code tree lives in an on-chip table with one node per row. Each row is either a branch, which names two child rows, or a leaf, which carries a symbol. From row 0, the walker takes one bit per cycle and steps to a child row. When it lands on a leaf, it emits the symbol and goes back to row 0. A codeword of n bits therefore costs n+1 cycles, and no wide shifter is needed.

The table is filled through a write port while `load_mode` is high. Decoding is held off during that time. Bits arrive with a valid/ready handshake. Symbols leave through a registered valid/ready output, and a stalled consumer stops bit intake. If a branch points at a row beyond the highest row written since reset, an error pulse is raised and the walk starts again from row 0.

Top module: `huff_tree_decoder`

## Requirements
- R1: A branch word has bit 18 set, its 0-child row in bits 17:9 and its 1-child row in bits 8:0. An accepted input bit of 0 moves the walk to the 0-child, and a bit of 1 moves it to the 1-child.
- R2: A leaf word has bit 18 clear and its symbol in bits 7:0. Reaching a leaf places that symbol on `sym_data` with `sym_valid` high on the following cycle.
- R3: With bits always offered and the output always accepted, `bit_ready` is high for the n cycles that take the bits of an n-bit codeword, then low for one cycle while the leaf is read, so each codeword takes n+1 cycles.
- R4: Every walk starts at row 0. After a leaf, the walk returns to row 0 and no offered bit is lost, so back-to-back codewords decode in order.
- R5: While `bit_valid` is low, the walker stays on its current row and the decoded sequence is unchanged.
- R6: While `sym_valid` is high and `sym_ready` is low, `bit_ready` is low and `sym_data` and `sym_valid` hold their values.
- R7: A synchronous reset clears `sym_valid` and `err` and returns the walk to row 0.
- R8: Table writes take effect only while `load_mode` is high, and a write strobe with `load_mode` low has no effect. `bit_ready` is low during loading and for one cycle after `load_mode` falls.
- R9: If an accepted bit selects a child row above the highest row written since reset, `err` is high for the next cycle and the walk restarts at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_mode | input | 1 | Table load window; decoding is paused while high |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 9 | Table row to write |
| wr_data | input | 19 | Node word to write |
| bit_valid | input | 1 | Input bit is offered |
| bit_in | input | 1 | Coded bit |
| bit_ready | output | 1 | Walker takes the offered bit this cycle |
| sym_valid | output | 1 | Decoded symbol is present |
| sym_data | output | 8 | Decoded symbol |
| sym_ready | input | 1 | Consumer accepts the symbol |
| err | output | 1 | One-cycle pulse: child row out of the written range |

## Verification
The assertions check the following on every cycle: intake is blocked during loading and during an output stall, a stalled symbol stays stable, an idle input holds the current row, reset clears the outputs, and an error always leaves the walk at row 0. Other properties only show up in the bench's scenarios. These are the decoded symbol order across back-to-back codewords, the n+1 cycle count per codeword, that a write strobe outside the load window has no effect, and recovery to a correct decode after an out-of-range branch. The bench's reference model predicts every output on every cycle, under input gaps and consumer stalls.

// File: rtl/huff_pkg.sv
package huff_pkg;

   localparam int DEF_SYM_W = 8;
   localparam int DEF_IDX_W = 9;

   // node word must hold either a branch (flag + two rows) or a leaf (flag + symbol)
   function automatic int node_width(input int sym_w, input int idx_w);
      int br;
      int lf;
      br = 1 + 2 * idx_w;
      lf = 1 + sym_w;
      return (br > lf) ? br : lf;
   endfunction

endpackage

// File: rtl/huff_node_ram.sv
module huff_node_ram #(
   parameter int IDX_W  = 9,
   parameter int WORD_W = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_go,
   input  logic [IDX_W-1:0]  wr_row,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rd_row,
   output logic [WORD_W-1:0] rd_word,
   output logic              any_rows,
   output logic [IDX_W-1:0]  top_row
);
   localparam int ROWS = 1 << IDX_W;

   logic [WORD_W-1:0] store [ROWS];

   always_ff @(posedge clk) begin
      if (wr_go)
         store[wr_row] <= wr_word;
      rd_word <= store[rd_row];
   end

   // highest row written since reset, used for child range checks
   always_ff @(posedge clk) begin
      if (rst) begin
         any_rows <= 1'b0;
         top_row  <= '0;
      end else if (wr_go) begin
         any_rows <= 1'b1;
         if (!any_rows || wr_row > top_row)
            top_row <= wr_row;
      end
   end

   p_top_grows_r8: assert property (@(posedge clk) disable iff (rst)
      wr_go |=> any_rows && (top_row >= $past(wr_row)));

   p_top_still_r8: assert property (@(posedge clk) disable iff (rst)
      !wr_go |=> $stable(top_row) && $stable(any_rows));

endmodule

// File: rtl/huff_walker.sv
module huff_walker #(
   parameter int SYM_W        = 8,
   parameter int IDX_W        = 9,
   parameter int WORD_W       = 19,
   parameter bit CHECK_BOUNDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_mode,
   input  logic [WORD_W-1:0] node_word,
   input  logic              any_rows,
   input  logic [IDX_W-1:0]  top_row,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              out_busy,
   output logic              bit_ready,
   output logic              leaf_fire,
   output logic [SYM_W-1:0]  leaf_sym,
   output logic [IDX_W-1:0]  next_row,
   output logic              err
);
   localparam int FLAG_B = WORD_W - 1;
   localparam int ZERO_H = 2 * IDX_W - 1;
   localparam int ZERO_L = IDX_W;

   logic             primed;
   logic [IDX_W-1:0] cur_row;
   logic             active;
   logic             is_branch;
   logic             take;
   logic [IDX_W-1:0] child;
   logic             bad_child;

   assign active    = primed && !load_mode;
   assign is_branch = node_word[FLAG_B];
   assign bit_ready = active && is_branch && !out_busy;
   assign take      = bit_ready && bit_valid;
   assign child     = bit_in ? node_word[IDX_W-1:0] : node_word[ZERO_H:ZERO_L];
   assign leaf_fire = active && !is_branch && !out_busy;
   assign leaf_sym  = node_word[SYM_W-1:0];

   generate
      if (CHECK_BOUNDS) begin : g_bounds
         assign bad_child = take && (!any_rows || child > top_row);
      end else begin : g_nobounds
         assign bad_child = 1'b0;
      end
   endgenerate

   always_comb begin
      next_row = cur_row;
      if (rst || load_mode)
         next_row = '0;
      else if (take)
         next_row = bad_child ? '0 : child;
      else if (leaf_fire)
         next_row = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         primed  <= 1'b0;
         cur_row <= '0;
         err     <= 1'b0;
      end else begin
         primed  <= !load_mode;
         cur_row <= next_row;
         err     <= bad_child;
      end
   end

   p_load_blocks_r8: assert property (@(posedge clk) disable iff (rst)
      load_mode |-> !bit_ready);

   p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
      out_busy |-> !bit_ready && !leaf_fire);

   p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (active && is_branch && !bit_valid) |=> $stable(cur_row));

   p_err_root_r9: assert property (@(posedge clk) disable iff (rst)
      err |-> cur_row == '0);

   p_leaf_root_r4: assert property (@(posedge clk) disable iff (rst)
      leaf_fire |=> cur_row == '0);

endmodule

// File: rtl/huff_sym_out.sv
module huff_sym_out #(
   parameter int SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             leaf_fire,
   input  logic [SYM_W-1:0] leaf_sym,
   input  logic             sym_ready,
   output logic             out_busy,
   output logic             sym_valid,
   output logic [SYM_W-1:0] sym_data
);
   assign out_busy = sym_valid && !sym_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_valid <= 1'b0;
         sym_data  <= '0;
      end else if (leaf_fire) begin
         sym_valid <= 1'b1;
         sym_data  <= leaf_sym;
      end else if (sym_ready) begin
         sym_valid <= 1'b0;
      end
   end

   p_stall_stable_r6: assert property (@(posedge clk) disable iff (rst)
      (sym_valid && !sym_ready) |=> sym_valid && $stable(sym_data));

   p_leaf_emits_r2: assert property (@(posedge clk) disable iff (rst)
      leaf_fire |=> sym_valid && sym_data == $past(leaf_sym));

   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> !sym_valid);

endmodule

// File: rtl/huff_tree_decoder.sv
module huff_tree_decoder
   import huff_pkg::*;
#(
   parameter int SYM_W        = DEF_SYM_W,
   parameter int IDX_W        = DEF_IDX_W,
   parameter bit CHECK_BOUNDS = 1'b1,
   localparam int WORD_W      = node_width(SYM_W, IDX_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_mode,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              bit_valid,
   input  logic              bit_in,
   output logic              bit_ready,
   output logic              sym_valid,
   output logic [SYM_W-1:0]  sym_data,
   input  logic              sym_ready,
   output logic              err
);
   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must lie in 1..12");
      end
      if (SYM_W < 1) begin : g_bad_sym
         $error("SYM_W must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] node_word;
   logic              any_rows;
   logic [IDX_W-1:0]  top_row;
   logic [IDX_W-1:0]  next_row;
   logic              leaf_fire;
   logic [SYM_W-1:0]  leaf_sym;
   logic              out_busy;
   logic              wr_go;

   assign wr_go = load_mode && wr_en;

   huff_node_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W)) i_ram (
      .clk(clk), .rst(rst), .wr_go(wr_go), .wr_row(wr_addr), .wr_word(wr_data),
      .rd_row(next_row), .rd_word(node_word), .any_rows(any_rows), .top_row(top_row)
   );

   huff_walker #(.SYM_W(SYM_W), .IDX_W(IDX_W), .WORD_W(WORD_W),
                 .CHECK_BOUNDS(CHECK_BOUNDS)) i_walk (
      .clk(clk), .rst(rst), .load_mode(load_mode), .node_word(node_word),
      .any_rows(any_rows), .top_row(top_row), .bit_valid(bit_valid), .bit_in(bit_in),
      .out_busy(out_busy), .bit_ready(bit_ready), .leaf_fire(leaf_fire),
      .leaf_sym(leaf_sym), .next_row(next_row), .err(err)
   );

   huff_sym_out #(.SYM_W(SYM_W)) i_out (
      .clk(clk), .rst(rst), .leaf_fire(leaf_fire), .leaf_sym(leaf_sym),
      .sym_ready(sym_ready), .out_busy(out_busy), .sym_valid(sym_valid),
      .sym_data(sym_data)
   );

   p_err_reset_r7: assert property (@(posedge clk)
      rst |=> !err);

endmodule

// File: tb/test_huff_tree_decoder.sv
module test_huff_tree_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_mode = 1'b1;
   logic        wr_en = 1'b0;
   logic [8:0]  wr_addr = '0;
   logic [18:0] wr_data = '0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic        sym_ready = 1'b1;
   logic        bit_ready;
   logic        sym_valid;
   logic [7:0]  sym_data;
   logic        err;

   int n_cmp = 0;
   int n_bad = 0;
   int accepted = 0;
   int err_seen = 0;
   int got_q[$];
   int bits_q[$];

   // reference model state
   int  m_mem [512];
   bit  m_primed = 0;
   int  m_cur = 0;
   bit  m_sv = 0;
   int  m_sd = 0;
   bit  m_err = 0;
   bit  m_any = 0;
   int  m_top = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   huff_tree_decoder i_huff_tree_decoder (
      .clk(clk), .rst(rst), .load_mode(load_mode), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .bit_valid(bit_valid), .bit_in(bit_in), .bit_ready(bit_ready),
      .sym_valid(sym_valid), .sym_data(sym_data), .sym_ready(sym_ready), .err(err)
   );

   function automatic int branch(input int zero_row, input int one_row);
      return (1 << 18) | (zero_row << 9) | one_row;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit m_ready();
      return m_primed && !load_mode && m_mem[m_cur][18] && !(m_sv && !sym_ready);
   endfunction

   // one cycle: drive, compare against model, then advance model at the edge
   task automatic step(input bit ld, input bit we, input int wa, input int wd,
                       input bit use_bits, input bit sr);
      bit exp_ready;
      bit leaf;
      bit tk;
      int child;
      @(negedge clk);
      load_mode = ld;
      wr_en     = we;
      wr_addr   = wa[8:0];
      wr_data   = wd[18:0];
      sym_ready = sr;
      bit_valid = use_bits && (bits_q.size() > 0);
      bit_in    = (bits_q.size() > 0) ? bits_q[0][0] : 1'b0;
      #1;
      exp_ready = m_ready();
      check("R3 bit_ready", int'(bit_ready), int'(exp_ready));
      check("R2 sym_valid", int'(sym_valid), int'(m_sv));
      if (m_sv) check("R2 sym_data", int'(sym_data), m_sd);
      check("R9 err", int'(err), int'(m_err));
      if (err) err_seen++;
      if (sym_valid && sym_ready) got_q.push_back(int'(sym_data));
      tk = bit_ready && bit_valid;
      if (tk) begin
         accepted++;
         void'(bits_q.pop_front());
      end
      @(posedge clk);
      leaf  = m_primed && !ld && !m_mem[m_cur][18] && !(m_sv && !sr);
      tk    = exp_ready && bit_valid;
      child = bit_in ? (m_mem[m_cur] & 511) : ((m_mem[m_cur] >> 9) & 511);
      m_err = tk && (!m_any || child > m_top);
      if (leaf) begin
         m_sv = 1;
         m_sd = m_mem[m_cur] & 255;
      end else if (sr) m_sv = 0;
      if (ld) m_cur = 0;
      else if (tk) m_cur = m_err ? 0 : child;
      else if (leaf) m_cur = 0;
      if (ld && we) begin
         m_mem[wa] = wd;
         if (!m_any || wa > m_top) m_top = wa;
         m_any = 1;
      end
      m_primed = !ld;
   endtask

   task automatic push_code(input int code, input int len);
      for (int k = len - 1; k >= 0; k--) bits_q.push_back((code >> k) & 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) m_mem[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 reset sym_valid", int'(sym_valid), 0);
      check("R7 reset err", int'(err), 0);
      rst = 1'b0;

      // tree: 0->0x41, 10->0x42, 110->0x43, 111->0x44
      step(1, 1, 0, branch(1, 2), 0, 1);
      step(1, 1, 1, 'h41, 0, 1);
      step(1, 1, 2, branch(3, 4), 0, 1);
      step(1, 1, 3, 'h42, 0, 1);
      step(1, 1, 4, branch(5, 6), 0, 1);
      step(1, 1, 5, 'h43, 0, 1);
      step(1, 1, 6, 'h44, 0, 1);
      check("R8 no intake while loading", int'(bit_ready), 0);
      step(0, 0, 0, 0, 0, 1);   // prime cycle after load
      check("R8 blocked in prime cycle", int'(bit_ready), 0);

      // R3/R4: back-to-back codewords, 9 bits, 4 symbols -> 13 cycles
      push_code(0, 1); push_code(2, 2); push_code(6, 3); push_code(7, 3);
      accepted = 0;
      got_q.delete();
      for (int c = 0; c < 13; c++) step(0, 0, 0, 0, 1, 1);
      check("R3 bits taken in 13 cycles", accepted, 9);
      step(0, 0, 0, 0, 1, 1);
      check("R4 symbol count", got_q.size(), 4);
      if (got_q.size() == 4) begin
         check("R1 sym0", got_q[0], 'h41);
         check("R1 sym1", got_q[1], 'h42);
         check("R4 sym2", got_q[2], 'h43);
         check("R4 sym3", got_q[3], 'h44);
      end

      // R5: gaps in bit_valid
      got_q.delete();
      push_code(6, 3); push_code(2, 2);
      for (int c = 0; c < 16; c++) step(0, 0, 0, 0, (c % 3) == 1, 1);
      for (int c = 0; c < 4; c++) step(0, 0, 0, 0, 0, 1);
      check("R5 gap decode count", got_q.size(), 2);
      if (got_q.size() == 2) begin
         check("R5 gap sym0", got_q[0], 'h43);
         check("R5 gap sym1", got_q[1], 'h42);
      end

      // R6: consumer stall
      got_q.delete();
      push_code(0, 1); push_code(7, 3); push_code(0, 1);
      for (int c = 0; c < 12; c++) begin
         step(0, 0, 0, 0, 1, c > 8);
         if (sym_valid && c < 8) check("R6 no intake under stall", int'(bit_ready), 0);
      end
      for (int c = 0; c < 8; c++) step(0, 0, 0, 0, 1, 1);
      check("R6 stall decode count", got_q.size(), 3);
      if (got_q.size() == 3) check("R6 stalled order", got_q[1], 'h44);

      // R8: write strobe outside load window is ignored
      got_q.delete();
      step(0, 1, 1, 'h99, 0, 1);
      push_code(0, 1);
      for (int c = 0; c < 4; c++) step(0, 0, 0, 0, 1, 1);
      check("R8 ignored write count", got_q.size(), 1);
      if (got_q.size() == 1) check("R8 ignored write symbol", got_q[0], 'h41);

      // R9: branch to row 50 (above row 6) flags error and restarts at row 0
      step(1, 1, 2, branch(3, 50), 0, 1);
      step(0, 0, 0, 0, 0, 1);
      err_seen = 0;
      got_q.delete();
      push_code(3, 2); push_code(0, 1);
      for (int c = 0; c < 8; c++) step(0, 0, 0, 0, 1, 1);
      check("R9 error pulses", err_seen, 1);
      check("R9 recovery count", got_q.size(), 1);
      if (got_q.size() == 1) check("R9 recovery symbol", got_q[0], 'h41);

      // R7: reset mid-stream
      push_code(7, 3);
      step(0, 0, 0, 0, 1, 1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R7 reset clears sym_valid", int'(sym_valid), 0);
      check("R7 reset clears err", int'(err), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule